// File: doc/BRIEF.md
# Block-Transfer Configuration Slave for a Clock Generator

This block is a two-wire serial slave, limited to standard-mode rates, that holds seven 8-bit configuration bytes for a clock synthesizer. A host changes the bytes with a block write and checks them with a block read. Neither kind of transfer carries a register pointer. A write always fills the bytes upward from byte 0. A read always returns a byte count, followed by every byte in order. The register contents appear on a flat output bus for the clock logic next to the block.

The slave samples SCL and SDA with the system clock. Each line passes through a two-flop synchronizer and then a stability filter. The slave finds start and stop conditions from SDA edges that occur while the filtered SCL is high. It pulls SDA low through an open-drain output enable, `sda_drive_low`, and never drives SDA high.

The controller is a single FSM with these states:
- `S_IDLE`: waits for a start.
- `S_ADDR`: shifts in the address byte.
- `S_AACK`: acknowledges a matching address.
- `S_WRX`: receives a write byte.
- `S_WACK`: acknowledges a write byte.
- `S_RDX`: shifts out a read byte.
- `S_RACK`: samples the host acknowledge.
- `S_IGNORE`: keeps SDA released until the next start or stop.

The transitions are:
- start (from any state) goes to `S_ADDR`.
- stop (from any state) goes to `S_IDLE`.
- `S_ADDR` goes to `S_AACK` on a matching address and to `S_IGNORE` on any other address.
- `S_AACK` goes to `S_WRX` for a write and to `S_RDX` for a read.
- `S_WRX` and `S_WACK` alternate.
- `S_RDX` goes to `S_RACK`.
- `S_RACK` goes back to `S_RDX` when the host acknowledges and to `S_IGNORE` when it does not.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: The address byte D2h selects a write and D3h selects a read. The slave acknowledges either one by driving SDA low during the ninth clock.
- R2: In a write, the slave acknowledges the address, the command byte, the byte-count byte and every data byte.
- R3: In a write, the first two bytes after the address are discarded. The data bytes that follow load byte 0, then byte 1, and so on, with the MSB received first. Byte k sits at `cfg_bytes[8k+7:8k]`.
- R4: A stop after any complete byte ends the write. Bytes written before the stop keep their new values, and bytes not reached keep their old values.
- R5: A read first sends the count 7 and then bytes 0 to 6, MSB first. When the host keeps acknowledging past byte 6, each further byte reads FFh.
- R6: When the host does not acknowledge a read byte, the slave releases SDA until the next start or stop.
- R7: After reset, the bytes 0 to 6 are 00h, FEh, FFh, ECh, FFh, FFh, 06h, and SDA is released.
- R8: The slave acknowledges write data bytes beyond byte 6 but does not store them.
- R9: The slave does not acknowledge any other address byte, and it ignores the bus until the next start.
- R10: The slave ignores a pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks.
- R11: A start, including a repeated start in the middle of a transfer, restarts the address phase. A stop returns the slave to idle.
- R12: `sda_drive_low` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfg_bytes | output | 56 | Configuration bytes; byte k at bits 8k+7:8k |

## Verification
The assertions assume that every SCL and SDA level the host means to produce lasts much longer than the synchronizer plus the filter. They also assume that the host changes SDA only while SCL is low, except to form a start or a stop. The bench holds each quarter bit for 20 system clocks and moves its SDA only during the low phase. Its one exception is a deliberate two-clock glitch on each line. Host and slave share SDA through a wired-AND in the bench, so acknowledges and read bits are sampled in the middle of the high phase, where neither side is changing the line.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_WRX,
        S_WACK,
        S_RDX,
        S_RACK,
        S_IGNORE
    } slv_state_t;
endpackage

// File: rtl/line_glitch_filter.sv
module line_glitch_filter #(
    parameter int STAGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    logic [1:0]        sync;
    logic [STAGES-1:0] hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync  <= 2'b11;
            hist  <= '1;
            clean <= 1'b1;
        end else begin
            sync <= {sync[0], raw};
            hist <= {hist[STAGES-2:0], sync[1]};
            if (&hist)
                clean <= 1'b1;
            else if (~|hist)
                clean <= 1'b0;
        end
    end

    // R10
    filt_rise_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clean) |-> $past(sync[1]));
endmodule

// File: rtl/cfg_byte_bank.sv
module cfg_byte_bank #(
    parameter int                      NBYTES   = 7,
    parameter logic [NBYTES*8-1:0]     DEFAULTS = '0,
    localparam int                     IW       = $clog2(NBYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NBYTES*8-1:0]   bytes_q
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bytes_q[g*8 +: 8] <= DEFAULTS[g*8 +: 8];
            else if (wr_en && wr_idx == IW'(g))
                bytes_q[g*8 +: 8] <= wr_data;
        end
    end

    // R8
    wr_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IW'(NBYTES)));
endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
    import cfgi2c_pkg::*;
#(
    parameter int                  FILT_LEN = 4,
    parameter int                  NBYTES   = 7,
    parameter logic [7:0]          WR_ADDR  = 8'hD2,
    parameter logic [7:0]          RD_ADDR  = 8'hD3,
    parameter logic [NBYTES*8-1:0] DEFAULTS = 56'h06_FF_FF_EC_FF_FE_00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                sda_drive_low,
    output logic [NBYTES*8-1:0] cfg_bytes
);
    localparam int IW  = $clog2(NBYTES + 1);
    localparam int WCW = $clog2(NBYTES + 3);
    localparam logic [WCW-1:0] WMAX = WCW'(NBYTES + 2);

    // filtered lines: index 0 = SCL, 1 = SDA
    logic [1:0] raw_lines, flt_lines;
    assign raw_lines = {sda_in, scl_in};
    for (genvar g = 0; g < 2; g++) begin : g_filt
        line_glitch_filter #(.STAGES(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_lines[g]),
            .clean(flt_lines[g])
        );
    end

    logic scl_f, sda_f, scl_q, sda_q;
    assign scl_f = flt_lines[0];
    assign sda_f = flt_lines[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    logic scl_rise, scl_fall, start_evt, stop_evt;
    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;

    slv_state_t state, nxt;
    logic [3:0]     bitcnt;
    logic [7:0]     rx_sh, tx_sh;
    logic           is_read, nack_q;
    logic [WCW-1:0] wcnt, widx_full;
    logic [IW-1:0]  ridx;
    logic           wr_en;

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_evt)
            nxt = S_ADDR;
        else if (stop_evt)
            nxt = S_IDLE;
        else begin
            unique case (state)
                S_IDLE, S_IGNORE: nxt = state;
                S_ADDR: if (scl_fall && bitcnt == 4'd8)
                            nxt = (rx_sh == WR_ADDR || rx_sh == RD_ADDR) ? S_AACK : S_IGNORE;
                S_AACK: if (scl_fall) nxt = is_read ? S_RDX : S_WRX;
                S_WRX:  if (scl_fall && bitcnt == 4'd8) nxt = S_WACK;
                S_WACK: if (scl_fall) nxt = S_WRX;
                S_RDX:  if (scl_fall && bitcnt == 4'd7) nxt = S_RACK;
                S_RACK: if (scl_fall) nxt = nack_q ? S_IGNORE : S_RDX;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            rx_sh   <= '0;
            tx_sh   <= '1;
            is_read <= 1'b0;
            nack_q  <= 1'b0;
            wcnt    <= '0;
            ridx    <= '0;
        end else if (start_evt) begin
            bitcnt <= '0;
        end else begin
            unique case (state)
                S_ADDR: begin
                    if (scl_rise) begin
                        rx_sh  <= {rx_sh[6:0], sda_f};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        is_read <= rx_sh[0];
                        wcnt    <= '0;
                        ridx    <= '0;
                    end
                end
                S_AACK: if (scl_fall) begin
                    bitcnt <= '0;
                    tx_sh  <= 8'(NBYTES);
                end
                S_WRX: begin
                    if (scl_rise) begin
                        rx_sh  <= {rx_sh[6:0], sda_f};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8 && wcnt != WMAX) begin
                        wcnt <= wcnt + WCW'(1);
                    end
                end
                S_WACK: if (scl_fall) bitcnt <= '0;
                S_RDX: if (scl_fall) begin
                    bitcnt <= bitcnt + 4'd1;
                    tx_sh  <= {tx_sh[6:0], 1'b1};
                end
                S_RACK: begin
                    if (scl_rise)
                        nack_q <= sda_f;
                    else if (scl_fall) begin
                        bitcnt <= '0;
                        if (ridx < IW'(NBYTES)) begin
                            tx_sh <= cfg_bytes[{ridx, 3'b000} +: 8];
                            ridx  <= ridx + IW'(1);
                        end else begin
                            tx_sh <= 8'hFF;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign widx_full = wcnt - WCW'(2);
    assign wr_en = (state == S_WRX) && scl_fall && (bitcnt == 4'd8) &&
                   (wcnt >= WCW'(2)) && (widx_full < WCW'(NBYTES));

    cfg_byte_bank #(.NBYTES(NBYTES), .DEFAULTS(DEFAULTS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (widx_full[IW-1:0]),
        .wr_data(rx_sh),
        .bytes_q(cfg_bytes)
    );

    // outputs
    always_comb begin
        unique case (state)
            S_AACK, S_WACK: sda_drive_low = 1'b1;
            S_RDX:          sda_drive_low = ~tx_sh[7];
            default:        sda_drive_low = 1'b0;
        endcase
    end

    // R1
    addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_AACK) |-> (rx_sh == WR_ADDR || rx_sh == RD_ADDR));
    // R2
    bitcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd8);
    // R11
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == S_ADDR && bitcnt == 4'd0));
    // R11
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !start_evt) |=> (state == S_IDLE && !sda_drive_low));
    // R12
    sda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_f);
    // R6
    ignore_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_RACK && state == S_IGNORE) |-> !sda_drive_low);
endmodule

// File: tb/clkgen_cfg_slave_test.sv
module clkgen_cfg_slave_test;
    localparam int Q = 20;
    localparam logic [55:0] DEF = 56'h06_FF_FF_EC_FF_FE_00;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        host_sda = 1'b1;
    logic        sda_drive_low;
    logic        sda_bus;
    logic [55:0] cfg;
    logic [55:0] model;

    assign sda_bus = host_sda & ~sda_drive_low;

    clkgen_cfg_slave uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl),
        .sda_in       (sda_bus),
        .sda_drive_low(sda_drive_low),
        .cfg_bytes    (cfg)
    );

    int total = 0;
    int bad = 0;
    int viol = 0;

    typedef struct {
        string  req;
        longint val;
    } item_t;
    item_t  exp_q[$];
    longint obs_q[$];

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                item_t  e;
                longint o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                check(e.req, o, e.val);
            end
        end
    end

    // R12 observer
    logic prev_low = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl && sda_drive_low != prev_low) viol++;
        prev_low <= sda_drive_low;
    end

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_out(logic b);
        host_sda = b; qw();
        scl = 1'b1; qw(); qw();
        scl = 1'b0; qw();
    endtask

    task automatic bit_in(output logic b);
        host_sda = 1'b1; qw();
        scl = 1'b1; qw();
        b = sda_bus; qw();
        scl = 1'b0; qw();
    endtask

    task automatic bus_start();
        host_sda = 1'b1; qw();
        scl = 1'b1; qw();
        host_sda = 1'b0; qw();
        scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; qw();
        scl = 1'b1; qw();
        host_sda = 1'b1; qw(); qw();
    endtask

    // ack expected as 0 on the wire when exp_ack is set
    task automatic send_byte(logic [7:0] v, string req, logic exp_ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        exp_q.push_back('{req, exp_ack ? 64'd0 : 64'd1});
        obs_q.push_back(longint'(a));
    endtask

    task automatic recv_byte(logic [7:0] exp, string req, logic host_nack);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            logic b;
            bit_in(b);
            v[i] = b;
        end
        exp_q.push_back('{req, longint'(exp)});
        obs_q.push_back(longint'(v));
        bit_out(host_nack);
    endtask

    task automatic wait_sb();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic b;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        model = DEF;
        check("R7 reset bytes", longint'(cfg), longint'(DEF));
        check("R7 reset sda released", longint'(sda_drive_low), 0);

        // R1 R2 R3 R4: short write, stop after third data byte
        bus_start();
        send_byte(8'hD2, "R1 write addr ack", 1'b1);
        send_byte(8'h5A, "R2 cmd ack", 1'b1);
        send_byte(8'h33, "R2 count ack", 1'b1);
        send_byte(8'hA1, "R2 data0 ack", 1'b1);
        send_byte(8'hB2, "R2 data1 ack", 1'b1);
        send_byte(8'hC3, "R2 data2 ack", 1'b1);
        bus_stop();
        wait_sb();
        model[23:0] = 24'hC3_B2_A1;
        check("R3 R4 partial write", longint'(cfg), longint'(model));

        // R5: full read plus one extra byte
        bus_start();
        send_byte(8'hD3, "R1 read addr ack", 1'b1);
        recv_byte(8'd7, "R5 byte count", 1'b0);
        for (int k = 0; k < 7; k++) recv_byte(model[k*8 +: 8], "R5 read byte", 1'b0);
        recv_byte(8'hFF, "R5 beyond last", 1'b1);
        bus_stop();
        wait_sb();

        // R8: nine data bytes, last two ignored
        bus_start();
        send_byte(8'hD2, "R1 write addr ack", 1'b1);
        send_byte(8'h00, "R2 cmd ack", 1'b1);
        send_byte(8'h07, "R2 count ack", 1'b1);
        for (int k = 0; k < 9; k++) begin
            logic [7:0] d;
            d = 8'(8'h11 * (k + 1));
            send_byte(d, "R8 data ack", 1'b1);
            if (k < 7) model[k*8 +: 8] = d;
        end
        bus_stop();
        wait_sb();
        check("R8 extra bytes ignored", longint'(cfg), longint'(model));

        // R9: wrong address
        bus_start();
        send_byte(8'hA4, "R9 wrong addr nack", 1'b0);
        send_byte(8'h55, "R9 ignored byte nack", 1'b0);
        bus_stop();
        wait_sb();
        check("R9 regs unchanged", longint'(cfg), longint'(model));

        // R6 R11: host nack, slave released, then repeated start write
        bus_start();
        send_byte(8'hD3, "R1 read addr ack", 1'b1);
        recv_byte(8'd7, "R5 byte count", 1'b0);
        recv_byte(model[7:0], "R6 byte0", 1'b1);
        bit_in(b);
        check("R6 released after nack", longint'(b), 1);
        bus_start();
        send_byte(8'hD2, "R11 repeated start addr ack", 1'b1);
        send_byte(8'h01, "R2 cmd ack", 1'b1);
        send_byte(8'h02, "R2 count ack", 1'b1);
        send_byte(8'h77, "R11 data ack", 1'b1);
        bus_stop();
        wait_sb();
        model[7:0] = 8'h77;
        check("R11 write after repeated start", longint'(cfg), longint'(model));

        // R10: glitches on both lines inside the first data bit
        bus_start();
        send_byte(8'hD2, "R1 write addr ack", 1'b1);
        send_byte(8'h00, "R2 cmd ack", 1'b1);
        send_byte(8'h00, "R2 count ack", 1'b1);
        host_sda = 1'b1;
        repeat (8) @(negedge clk);
        scl = 1'b1;
        repeat (2) @(negedge clk);
        scl = 1'b0;
        repeat (Q - 10) @(negedge clk);
        scl = 1'b1;
        repeat (5) @(negedge clk);
        host_sda = 1'b0;
        repeat (2) @(negedge clk);
        host_sda = 1'b1;
        repeat (Q - 7) @(negedge clk);
        qw();
        scl = 1'b0; qw();
        for (int i = 6; i >= 0; i--) bit_out(((8'hE7 >> i) & 8'h01) != 8'h00);
        bit_in(b);
        check("R10 ack after glitches", longint'(b), 0);
        bus_stop();
        wait_sb();
        model[7:0] = 8'hE7;
        check("R10 glitches ignored", longint'(cfg), longint'(model));

        // R4: stop right after the command byte
        bus_start();
        send_byte(8'hD2, "R1 write addr ack", 1'b1);
        send_byte(8'h99, "R2 cmd ack", 1'b1);
        bus_stop();
        wait_sb();
        check("R4 stop before data", longint'(cfg), longint'(model));

        check("R12 no sda change with scl high", longint'(viol), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule